// File: doc/BRIEF.md
# Display Frame Writeback Engine

The engine takes a stream of 32-bit ARGB pixels, already scaled by an upstream display compositor channel, and stores them as one frame in system memory. Software sets four registers and then starts one capture by setting a start bit. The registers give the frame's base address, the byte distance between line starts, the width and height in pixels, and a control word. The control word also holds a format code, a byte-lane mask and an alpha-write enable.

Pixels arrive on a valid/ready stream in raster order. For each pixel the engine issues one word write to a simple request/acknowledge memory port. Each write carries the pixel's address and a per-byte strobe. The line stride comes from the pitch register, so a line may be shorter than its stride. When the last write of the frame has been acknowledged, the engine clears the start bit and raises a one-cycle done pulse. It then stays idle until software starts it again.

Top module: `frame_writeback`

## Requirements
- R1: After reset every register reads zero, `mem_req`, `pix_ready` and `frame_done` are low.
- R2: Register offset 0 holds the base address, offset 1 the pitch in bytes, offset 2 the dimensions (width in bits [15:0], height in bits [31:16]) and offset 3 the control word. Each register reads back what was written while idle.
- R3: The control word layout is: bit 0 start/busy, bits [11:8] format code, bits [19:16] byte mask, bit 20 alpha enable, bit 24 read-only error flag. Writing bit 0 as 1 with format code 13 and a nonzero width and height starts a capture. Bit 0 then reads 1 until the frame completes.
- R4: Pixel x of line y, counted in raster order from 0, is written to base + y*pitch + 4*x. The line advances after width pixels.
- R5: Each write carries the pixel data unchanged. Its strobe equals the byte mask, with bit 3 (the alpha byte lane, data bits [31:24]) also cleared when alpha enable is 0.
- R6: Only one write is outstanding at a time. While `mem_req` is high without `mem_ack`, `pix_ready` is low and the address, data and strobe hold steady.
- R7: In the cycle after the last write of the frame is acknowledged, `frame_done` is high for exactly one cycle and control bit 0 reads 0.
- R8: Once the frame is complete, further input pixels are ignored. `pix_ready` stays low and no write is issued until the next start.
- R9: A start request with a format code other than 13, or with a zero width or height, sets the error flag and does not start. A valid start clears the flag.
- R10: Register writes made during a capture are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_valid | input | 1 | Input pixel valid |
| pix_data | input | 32 | Input pixel, ARGB with alpha in [31:24] |
| pix_ready | output | 1 | Engine accepts the pixel this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address of the write |
| mem_data | output | 32 | Write data |
| mem_strb | output | 4 | Byte strobes |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
Two events can fall on the same clock edge: the memory acknowledges the pending write, and a new pixel is accepted into the write register that is being freed. This works because `pix_ready` follows `mem_ack` combinationally. The bench provokes it by driving the acknowledge and the pixel valid at random with high probability. Back-to-back handovers therefore happen often, mixed with stalls on either side. Every completed write is compared in order against a queue of expected address, data and strobe values. A write that is dropped, duplicated or overwritten at a handover shows up as a mismatch or as a leftover queue entry.

// File: rtl/frame_writeback.sv
module frame_writeback #(
  parameter int AW = 32,
  parameter logic [3:0] FMT_ARGB = 4'd13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          pix_valid,
  input  logic [31:0]   pix_data,
  output logic          pix_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_data,
  output logic [3:0]    mem_strb,
  input  logic          mem_ack,
  output logic          frame_done
);

  logic [AW-1:0] base_q, pitch_q, line_q;
  logic [15:0]   width_q, height_q, x_q, y_q;
  logic [3:0]    fmt_q, mask_q;
  logic          alpha_q, err_q, busy_q, last_q;

  wire take  = pix_valid && pix_ready;
  wire fire  = mem_req && mem_ack;
  wire eol   = (x_q == width_q - 16'd1);
  wire eof   = eol && (y_q == height_q - 16'd1);
  wire start_ok = (reg_wdata[11:8] == FMT_ARGB) && (width_q != 16'd0) && (height_q != 16'd0);

  assign pix_ready = busy_q && !last_q && (!mem_req || mem_ack);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(base_q);
      2'd1:    reg_rdata = 32'(pitch_q);
      2'd2:    reg_rdata = {height_q, width_q};
      default: reg_rdata = {7'd0, err_q, 3'd0, alpha_q, mask_q, 4'd0, fmt_q, 7'd0, busy_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; pitch_q <= '0; width_q <= '0; height_q <= '0;
      fmt_q <= '0; mask_q <= '0; alpha_q <= 1'b0; err_q <= 1'b0;
      busy_q <= 1'b0; last_q <= 1'b0; line_q <= '0;
      x_q <= '0; y_q <= '0; frame_done <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0; mem_data <= '0; mem_strb <= '0;
    end else begin
      frame_done <= 1'b0;
      if (reg_we && !busy_q) begin
        case (reg_addr)
          2'd0: base_q  <= AW'(reg_wdata);
          2'd1: pitch_q <= AW'(reg_wdata);
          2'd2: begin width_q <= reg_wdata[15:0]; height_q <= reg_wdata[31:16]; end
          default: begin
            fmt_q   <= reg_wdata[11:8];
            mask_q  <= reg_wdata[19:16];
            alpha_q <= reg_wdata[20];
            if (reg_wdata[0]) begin
              err_q <= !start_ok;
              if (start_ok) begin
                busy_q <= 1'b1;
                line_q <= base_q;
                x_q    <= '0;
                y_q    <= '0;
              end
            end
          end
        endcase
      end
      if (take) begin
        mem_req  <= 1'b1;
        mem_addr <= line_q + AW'({x_q, 2'b00});
        mem_data <= pix_data;
        mem_strb <= mask_q & {alpha_q, 3'b111};
        if (eof) last_q <= 1'b1;
        if (eol) begin
          x_q    <= '0;
          y_q    <= y_q + 16'd1;
          line_q <= line_q + pitch_q;
        end else begin
          x_q <= x_q + 16'd1;
        end
      end else if (fire) begin
        mem_req <= 1'b0;
        if (last_q) begin
          last_q     <= 1'b0;
          busy_q     <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_strb));
  a_r6_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |-> !pix_ready);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r7_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy_q);
  a_r8_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !pix_ready);
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_strb & ~mask_q) == 4'd0) && (alpha_q || !mem_strb[3]));

endmodule

// File: tb/frame_writeback_bench.sv
module frame_writeback_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic pix_valid = 1'b0, pix_ready;
  logic [31:0] pix_data = '0;
  logic mem_req, mem_ack = 1'b0, frame_done;
  logic [31:0] mem_addr, mem_data;
  logic [3:0] mem_strb;

  int checks = 0, fails = 0;
  logic [31:0] qa[$], qd[$];
  logic [3:0]  qs[$];

  always #5 clk = ~clk;

  frame_writeback u_frame_writeback (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
    .mem_ack(mem_ack), .frame_done(frame_done));

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [31:0] p, int x, int y);
    return b + 32'(y) * p + 32'(4 * x);
  endfunction
  function automatic logic [3:0] exp_strb(logic [3:0] m, logic a);
    return a ? m : (m & 4'b0111);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_addr = 2'd3;
  endtask

  task automatic frame(logic [31:0] b, logic [31:0] p, int w, int h, logic [3:0] m, logic al, int ackp, int vp);
    logic [31:0] r;
    int x = 0, y = 0, got = 0, cyc = 0;
    bit poked = 0, done_seen = 0;
    wr(2'd0, b); wr(2'd1, p); wr(2'd2, {16'(h), 16'(w)});
    wr(2'd3, {11'd0, al, m, 4'd0, 4'd13, 7'd0, 1'b1});
    rd(2'd3, r);
    check("R3 busy bit after start", {r[24], r[0]}, 32'b01);
    while (!done_seen && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (got == w * h) begin
        check("R7 frame_done after last ack", frame_done, 1);
        done_seen = 1;
        pix_valid = 1'b0; mem_ack = 1'b0;
      end else begin
        reg_we = 1'b0;
        if (!poked && got == 2) begin
          reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hDEAD0000; poked = 1;
        end else reg_addr = 2'd3;
        mem_ack = ($urandom % 100) < ackp;
        pix_valid = (x + y * w < w * h) && (($urandom % 100) < vp);
        pix_data = $urandom;
        #1;
        if (reg_addr == 2'd3) check("R3 busy bit mid-frame", reg_rdata[0], 1);
        if (frame_done) check("R7 no early done", frame_done, 0);
        if (mem_req && mem_ack) begin
          check("R4 address", mem_addr, qa.pop_front());
          check("R5 data", mem_data, qd.pop_front());
          check("R5 strobe", mem_strb, qs.pop_front());
          got++;
        end
        if (pix_valid && pix_ready) begin
          qa.push_back(exp_addr(b, p, x, y));
          qd.push_back(pix_data);
          qs.push_back(exp_strb(m, al));
          if (x == w - 1) begin x = 0; y++; end else x++;
        end
      end
    end
    reg_we = 1'b0; reg_addr = 2'd3;
    check("R7 frame completed", done_seen, 1);
    #1 check("R3 go cleared", reg_rdata[0], 0);
    @(negedge clk);
    check("R7 single-cycle pulse", frame_done, 0);
    pix_valid = 1'b1; mem_ack = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R8 ready low after frame", pix_ready, 0);
      check("R8 no write after frame", mem_req, 0);
    end
    pix_valid = 1'b0; mem_ack = 1'b0;
    rd(2'd0, r);
    check("R10 base unchanged by busy write", r, b);
    check("R6 queue drained", qa.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready low", pix_ready, 0);
    check("R1 no request", mem_req, 0);
    check("R1 no done", frame_done, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      check("R1 register zero", r, 0);
    end
    wr(2'd0, 32'h1000_0040); rd(2'd0, r); check("R2 base", r, 32'h1000_0040);
    wr(2'd1, 32'h0000_1680); rd(2'd1, r); check("R2 pitch", r, 32'h0000_1680);
    wr(2'd2, 32'h0438_05A0); rd(2'd2, r); check("R2 dims", r, 32'h0438_05A0);
    wr(2'd3, 32'h0015_0D00); rd(2'd3, r); check("R2 control", r, 32'h0015_0D00);
    wr(2'd3, 32'h001F_0C01); rd(2'd3, r);
    check("R9 bad format error", r, 32'h011F_0C00);
    @(negedge clk); pix_valid = 1'b1; #1;
    check("R9 no start on bad format", pix_ready, 0);
    pix_valid = 1'b0;
    wr(2'd2, 32'h0003_0000);
    wr(2'd3, 32'h001F_0D01); rd(2'd3, r);
    check("R9 zero width error", {r[24], r[0]}, 32'b10);
    frame(32'h2000_0000, 32'd64, 5, 3, 4'hF, 1'b1, 70, 80);
    rd(2'd3, r); check("R9 error cleared by good start", r[24], 0);
    frame(32'h2000_1000, 32'd20, 5, 4, 4'hF, 1'b0, 100, 100);
    frame(32'h0000_0100, 32'd40, 7, 2, 4'h5, 1'b1, 30, 60);
    frame(32'h4000_0000, 32'd16, 1, 5, 4'hA, 1'b0, 90, 95);
    frame(32'h0010_0000, 32'd200, 9, 1, 4'hF, 1'b1, 50, 50);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule